// File: doc/BRIEF.md
# Transmit Word Queue with Mid-Parity Deadline Check

This block buffers the 16-bit data words that a remote terminal sends in reply to a transmit command. The host loads words through a small address-decoded write port. One address code pushes a word and another code empties the queue. The transmit engine pops the words in the order they were loaded, and it reads the occupancy count and an empty flag to pace itself.

Each word after the first must already sit in the queue when the engine reaches the middle of the parity bit of the word it is sending. The engine marks that moment with a strobe and says whether the message still needs more words. If the queue is empty at that strobe while words are still owed, the block raises a one-cycle underrun pulse. A push into a full queue is dropped and recorded in a sticky overflow flag, which only a flush clears. A master-reset pulse flushes the queue in the same way as the flush address.

Top module: `tx_word_queue`

## Requirements
- R1: A host write whose address bits [2:0] equal 3'b011 pushes `host_wdata_i`, whatever address bit 3 holds. `count_o` rises by one on the following cycle.
- R2: A host write whose address bits [2:0] equal 3'b010 empties the queue whatever data is written. On the next cycle `count_o` is 0 and `empty_o` is 1.
- R3: A one-cycle pulse on `mreset_i` empties the queue in the same way as R2.
- R4: When `pop_i` is high and the queue is not empty, the oldest word appears on `rd_data_o` one cycle later, with `rd_valid_o` high for that cycle. Words leave in load order.
- R5: `pop_i` while the queue is empty is ignored. `rd_valid_o` stays low and `count_o` stays 0.
- R6: A push while the queue holds DEPTH (32) words is dropped and sets `overflow_o`. The stored words and the count stay unchanged.
- R7: `overflow_o` stays high until a flush (R2 or R3), and the flush clears it.
- R8: A flush in the same cycle as a push wins, and the queue ends up empty.
- R9: When `mid_parity_i` and `more_words_i` are both high while `empty_o` is 1, `underrun_o` is high for exactly the next cycle.
- R10: `underrun_o` stays low when the queue holds a word at the strobe, or when `more_words_i` is low.
- R11: `count_o` and `empty_o` are registered and agree with each other. A push and a pop in the same cycle leave the count unchanged.
- R12: While `rst` is high, the block returns to count 0, empty 1, and no overflow, underrun or read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mreset_i | input | 1 | Master-reset pulse, flushes the queue |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 4 | Host register address (bits [2:0] decoded) |
| host_wdata_i | input | 16 | Host write data |
| pop_i | input | 1 | Engine request for the next word |
| mid_parity_i | input | 1 | Engine strobe at the middle of the parity bit |
| more_words_i | input | 1 | Engine still owes words for this message |
| rd_data_o | output | 16 | Popped word |
| rd_valid_o | output | 1 | `rd_data_o` holds a freshly popped word |
| count_o | output | 6 | Words held |
| empty_o | output | 1 | Queue holds no word |
| overflow_o | output | 1 | Sticky flag: a push was dropped |
| underrun_o | output | 1 | One-cycle pulse: deadline missed |

## Verification
The bench fills the queue to its limit and pushes one extra word, then drains all 32 entries. A design that let the extra word overwrite an entry, or that counted past 32, shows up as a wrong word or a wrong count. A master reset is applied in the same cycle as a push; a design that gave the push priority would be left holding one word. Pops on an empty queue are checked for a spurious read-valid. The underrun strobe is tried on an empty queue, on a non-empty queue and with no words owed, so a design that ignored the owed-words input or stretched the pulse would be caught. A push and a pop in the same cycle must leave the count flat.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    HOST_IDLE  = 2'd0,
    HOST_PUSH  = 2'd1,
    HOST_FLUSH = 2'd2
  } host_op_e;
endpackage

// File: rtl/txq_host_decode.sv
module txq_host_decode #(
  parameter int ADDR_W     = 4,
  parameter int DEC_W      = 3,
  parameter logic [DEC_W-1:0] PUSH_CODE  = 3'b011,
  parameter logic [DEC_W-1:0] FLUSH_CODE = 3'b010
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output txq_pkg::host_op_e op_o
);
  // only the low DEC_W address bits select the register
  logic [DEC_W-1:0] sel;
  assign sel = addr_i[DEC_W-1:0];

  always_comb begin
    op_o = txq_pkg::HOST_IDLE;
    if (wr_i) begin
      if (sel == FLUSH_CODE)     op_o = txq_pkg::HOST_FLUSH;
      else if (sel == PUSH_CODE) op_o = txq_pkg::HOST_PUSH;
    end
  end
endmodule

// File: rtl/txq_mem.sv
module txq_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] store [DEPTH];

  // simple dual port, synchronous read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we_i) store[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= store[raddr_i];
  end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          mid_parity_i,
  input  logic          more_words_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          overflow_o,
  output logic          underrun_o,
  output logic          rd_valid_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          empty_q, ovf_q, unr_q, rvld_q;
  logic          full, push_ok, pop_ok, push_drop;
  logic [CW-1:0] cnt_nxt;

  assign full      = (cnt_q == FULL_CNT);
  assign push_ok   = push_i && !full && !flush_i;
  assign push_drop = push_i && full && !flush_i;
  assign pop_ok    = pop_i && !empty_q && !flush_i;

  always_comb begin
    cnt_nxt = cnt_q;
    if (push_ok && !pop_ok)      cnt_nxt = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
      ovf_q   <= 1'b0;
      unr_q   <= 1'b0;
      rvld_q  <= 1'b0;
    end else begin
      // deadline check uses the occupancy seen before this edge
      unr_q  <= mid_parity_i && more_words_i && empty_q;
      rvld_q <= pop_ok;
      if (flush_i) begin
        wptr_q  <= '0;
        rptr_q  <= '0;
        cnt_q   <= '0;
        empty_q <= 1'b1;
        ovf_q   <= 1'b0;
      end else begin
        if (push_ok) wptr_q <= (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
        if (pop_ok)  rptr_q <= (rptr_q == LAST_IDX) ? '0 : rptr_q + 1'b1;
        if (push_drop) ovf_q <= 1'b1;
        cnt_q   <= cnt_nxt;
        empty_q <= (cnt_nxt == '0);
      end
    end
  end

  assign we_o       = push_ok;
  assign waddr_o    = wptr_q;
  assign re_o       = pop_ok;
  assign raddr_o    = rptr_q;
  assign count_o    = cnt_q;
  assign empty_o    = empty_q;
  assign overflow_o = ovf_q;
  assign underrun_o = unr_q;
  assign rd_valid_o = rvld_q;
endmodule

// File: rtl/tx_word_queue.sv
module tx_word_queue #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 4,
  parameter int DEC_W  = 3,
  parameter logic [DEC_W-1:0] PUSH_CODE  = 3'b011,
  parameter logic [DEC_W-1:0] FLUSH_CODE = 3'b010,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mreset_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              pop_i,
  input  logic              mid_parity_i,
  input  logic              more_words_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [CW-1:0]     count_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic              underrun_o
);
  txq_pkg::host_op_e op;
  logic          flush, push;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;

  txq_host_decode #(
    .ADDR_W(ADDR_W), .DEC_W(DEC_W),
    .PUSH_CODE(PUSH_CODE), .FLUSH_CODE(FLUSH_CODE)
  ) dec_i (
    .wr_i   (host_wr_i),
    .addr_i (host_addr_i),
    .op_o   (op)
  );

  assign flush = (op == txq_pkg::HOST_FLUSH) || mreset_i;
  assign push  = (op == txq_pkg::HOST_PUSH);

  txq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush),
    .push_i       (push),
    .pop_i        (pop_i),
    .mid_parity_i (mid_parity_i),
    .more_words_i (more_words_i),
    .we_o         (we),
    .waddr_o      (waddr),
    .re_o         (re),
    .raddr_o      (raddr),
    .count_o      (count_o),
    .empty_o      (empty_o),
    .overflow_o   (overflow_o),
    .underrun_o   (underrun_o),
    .rd_valid_o   (rd_valid_o)
  );

  txq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (host_wdata_i),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 4,
  parameter int DEC_W  = 3,
  parameter logic [DEC_W-1:0] PUSH_CODE  = 3'b011,
  parameter logic [DEC_W-1:0] FLUSH_CODE = 3'b010,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              mreset_i,
  input logic              host_wr_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              pop_i,
  input logic              mid_parity_i,
  input logic              more_words_i,
  input logic              rd_valid_o,
  input logic [CW-1:0]     count_o,
  input logic              empty_o,
  input logic              overflow_o,
  input logic              underrun_o
);
  logic fl, ps;
  assign fl = mreset_i || (host_wr_i && host_addr_i[DEC_W-1:0] == FLUSH_CODE);
  assign ps = host_wr_i && host_addr_i[DEC_W-1:0] == PUSH_CODE;

  p_push_r1: assert property (@(posedge clk) disable iff (rst)
    ps && !fl && !pop_i && count_o < CW'(DEPTH) |=> count_o == $past(count_o) + 1'b1);

  p_flush_r2: assert property (@(posedge clk) disable iff (rst)
    fl |=> count_o == '0 && empty_o && !overflow_o);

  p_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
    pop_i && empty_o |=> !rd_valid_o);

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (rst)
    ps && !fl && count_o == CW'(DEPTH) |=> overflow_o);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overflow_o && !fl |=> overflow_o);

  p_underrun_r9: assert property (@(posedge clk) disable iff (rst)
    mid_parity_i && more_words_i && empty_o |=> underrun_o);

  p_no_underrun_r10: assert property (@(posedge clk) disable iff (rst)
    !(mid_parity_i && more_words_i && empty_o) |=> !underrun_o);

  p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(DEPTH) && (empty_o == (count_o == '0)));

  p_reset_r12: assert property (@(posedge clk)
    rst |=> count_o == '0 && empty_o && !overflow_o && !underrun_o && !rd_valid_o);
endmodule

bind tx_word_queue txq_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DEC_W(DEC_W),
  .PUSH_CODE(PUSH_CODE), .FLUSH_CODE(FLUSH_CODE)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .mreset_i     (mreset_i),
  .host_wr_i    (host_wr_i),
  .host_addr_i  (host_addr_i),
  .pop_i        (pop_i),
  .mid_parity_i (mid_parity_i),
  .more_words_i (more_words_i),
  .rd_valid_o   (rd_valid_o),
  .count_o      (count_o),
  .empty_o      (empty_o),
  .overflow_o   (overflow_o),
  .underrun_o   (underrun_o)
);

// File: tb/tx_word_queue_tb_top.sv
module tx_word_queue_tb_top;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mreset_i = 1'b0;
  logic        host_wr_i = 1'b0;
  logic [3:0]  host_addr_i = '0;
  logic [15:0] host_wdata_i = '0;
  logic        pop_i = 1'b0;
  logic        mid_parity_i = 1'b0;
  logic        more_words_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        rd_valid_o;
  logic [5:0]  count_o;
  logic        empty_o, overflow_o, underrun_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  logic        exp_ovf = 1'b0;
  bit          done = 0;

  always #2 clk = ~clk;

  tx_word_queue dut_i (
    .clk(clk), .rst(rst), .mreset_i(mreset_i),
    .host_wr_i(host_wr_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .pop_i(pop_i), .mid_parity_i(mid_parity_i), .more_words_i(more_words_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .count_o(count_o),
    .empty_o(empty_o), .overflow_o(overflow_o), .underrun_o(underrun_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // monitor: compares each popped word against the scoreboard queue
  always @(posedge clk) begin
    #1;
    if (!rst && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "read valid with no word expected", 32'd1, 32'd0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rd_data_o == e, "R4", "popped word order", rd_data_o, e);
      end
    end
  end

  // driver: host write, scoreboard updated from the requirements
  task automatic host_write(input logic [3:0] a, input logic [15:0] d, input bit also_pop);
    host_wr_i = 1'b1; host_addr_i = a; host_wdata_i = d; pop_i = also_pop;
    if (a[2:0] == 3'b010) begin
      exp_q.delete(); exp_ovf = 1'b0;
    end else if (a[2:0] == 3'b011) begin
      if (exp_q.size() < DEPTH) exp_q.push_back(d);
      else exp_ovf = 1'b1;
    end
    @(negedge clk);
    host_wr_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      pop_i = 1'b1;
      @(negedge clk);
    end
    pop_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(count_o == 0 && empty_o, "R12", "count/empty in reset", {count_o, empty_o}, 32'd1);
    check(!overflow_o && !underrun_o && !rd_valid_o, "R12", "flags in reset",
          {overflow_o, underrun_o, rd_valid_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: push with address bit 3 clear and set
    host_write(4'b0011, 16'h1111, 0);
    check(count_o == 1, "R1", "count after one push", count_o, 1);
    host_write(4'b1011, 16'h2222, 0);
    host_write(4'b0011, 16'h3333, 0);
    host_write(4'b1011, 16'h4444, 0);
    host_write(4'b0011, 16'h5555, 0);
    check(count_o == 5 && !empty_o, "R1", "count after five pushes", count_o, 5);

    // R4: drain in order
    pop_n(5);
    check(count_o == 0 && empty_o, "R4", "count after drain", count_o, 0);

    // R5: pop on empty
    pop_n(1);
    check(count_o == 0 && empty_o, "R5", "count after empty pop", count_o, 0);

    // R9: underrun pulse lasts exactly one cycle
    mid_parity_i = 1'b1; more_words_i = 1'b1;
    @(negedge clk);
    mid_parity_i = 1'b0;
    check(underrun_o == 1'b1, "R9", "underrun after empty strobe", underrun_o, 1);
    @(negedge clk);
    check(underrun_o == 1'b0, "R9", "underrun one cycle only", underrun_o, 0);

    // R10: no words owed
    more_words_i = 1'b0; mid_parity_i = 1'b1;
    @(negedge clk);
    mid_parity_i = 1'b0;
    check(underrun_o == 1'b0, "R10", "no underrun when no words owed", underrun_o, 0);
    // R10: word present
    host_write(4'b0011, 16'hA5A5, 0);
    more_words_i = 1'b1; mid_parity_i = 1'b1;
    @(negedge clk);
    mid_parity_i = 1'b0; more_words_i = 1'b0;
    check(underrun_o == 1'b0, "R10", "no underrun with word loaded", underrun_o, 0);
    pop_n(1);

    // R11: push and pop together
    host_write(4'b0011, 16'h0B01, 0);
    host_write(4'b0011, 16'h0B02, 0);
    host_write(4'b0011, 16'h0B03, 1);
    check(count_o == 2, "R11", "count with push+pop", count_o, 2);
    pop_n(2);
    check(count_o == 0 && empty_o, "R11", "empty after drain", count_o, 0);

    // R2: flush address with arbitrary data
    host_write(4'b0011, 16'hC001, 0);
    host_write(4'b0011, 16'hC002, 0);
    host_write(4'b0011, 16'hC003, 0);
    host_write(4'b1010, 16'hFFFF, 0);
    check(count_o == 0 && empty_o, "R2", "count after flush write", count_o, 0);
    pop_n(1);

    // R3: master reset pulse
    host_write(4'b0011, 16'hD001, 0);
    host_write(4'b0011, 16'hD002, 0);
    mreset_i = 1'b1; exp_q.delete(); exp_ovf = 1'b0;
    @(negedge clk);
    mreset_i = 1'b0;
    check(count_o == 0 && empty_o, "R3", "count after master reset", count_o, 0);

    // R8: master reset and push in one cycle
    host_wr_i = 1'b1; host_addr_i = 4'b0011; host_wdata_i = 16'hE001; mreset_i = 1'b1;
    @(negedge clk);
    host_wr_i = 1'b0; mreset_i = 1'b0;
    check(count_o == 0 && empty_o, "R8", "flush beats push", count_o, 0);
    pop_n(1);

    // R6: fill, then push one more
    for (int i = 0; i < DEPTH; i++) host_write(4'b0011, 16'h6000 + 16'(i), 0);
    check(count_o == DEPTH && !overflow_o, "R6", "full without overflow", count_o, DEPTH);
    host_write(4'b0011, 16'hBEEF, 0);
    check(overflow_o == 1'b1, "R6", "overflow after drop", overflow_o, 1);
    check(count_o == DEPTH, "R6", "count held at full", count_o, DEPTH);
    pop_n(DEPTH);
    check(count_o == 0 && empty_o, "R6", "drained without extra word", count_o, 0);
    check(overflow_o == 1'b1, "R7", "overflow sticky after drain", overflow_o, 1);
    host_write(4'b0010, 16'h0000, 0);
    check(overflow_o == 1'b0, "R7", "flush clears overflow", overflow_o, 0);
    check(exp_q.size() == 0, "R4", "scoreboard empty at end", exp_q.size(), 0);

    done = 1;
    finish_run();
  end
endmodule